// File: doc/BRIEF.md
# Scatter-Gather Capture Ring

This block takes a byte stream from a capture source and stores it into eight scatter-gather buffers that are used in turn. Each buffer is made of a programmable number of fixed-size pages, and each page may sit anywhere in memory. A page table, loaded through a small write port, holds one page frame number per page of each buffer. For every accepted byte the block keeps a running offset inside the current buffer. It looks up the page frame for that offset and issues one memory write with the frame number and the offset within the page.

Software programs a stride, which is the number of bytes after which the current buffer counts as filled. The stride can be anything from one byte up to the full buffer length. When a buffer reaches the stride, the block raises an interrupt and reports the index of the buffer that completed, together with a free-running timestamp taken at that moment. It then moves on to the next buffer, starting again at offset zero. An interrupt that is still pending when a further completion arrives leaves an overrun flag set. A bad configuration keeps the engine idle and raises an error flag instead.

Top module: `sgcap_ring`

## Requirements
- R1: The write address is the page frame number stored for (current buffer, offset >> PAGE_W), concatenated above the low PAGE_W bits of the offset, i.e. `{pfn, offset[PAGE_W-1:0]}`. Table entries are written with `pt_we` at (`pt_buf`, `pt_page`).
- R2: Every byte handshaken on the input (`in_valid` and `in_ready` both high at a rising edge) produces exactly one memory write carrying that byte. The write is visible after the second rising edge that follows the handshake.
- R3: Each buffer receives exactly `cfg_stride` bytes at offsets 0 to stride-1. Buffers are used in the order 0, 1, …, NBUF-1, and then the sequence wraps to 0.
- R4: `irq` rises on the same edge as the write of a buffer's last (stride-th) byte. `irq_buf` then holds that buffer's index, and each completion is reported once.
- R5: `irq_stamp` holds the free-running cycle counter as it stood just before the edge on which `irq` rose. The counter is 0 during reset and counts up by one on every later edge.
- R6: `irq` stays high until `irq_clear` is sampled high. A clear drops both `irq` and `irq_overrun`, unless a completion lands on the same edge, in which case the completion wins.
- R7: A completion that arrives while `irq` is still high sets `irq_overrun`. `irq_buf` and `irq_stamp` then report the newest completion.
- R8: On enable, the configuration is rejected if `cfg_stride` is 0, if `cfg_stride` is larger than `cfg_pages`×2^PAGE_W, or if `cfg_pages` is 0 or above MAX_PAGES. A rejected configuration sets `cfg_err` and holds `in_ready` low until enable drops.
- R9: Dropping `cfg_enable` pulls `in_ready` low after the next edge. It also returns the engine to buffer 0 at offset 0, so the next enabled stream starts there.
- R10: With a valid configuration, `in_ready` is high two edges after `cfg_enable` rises and `cfg_err` is low. Cycles with `in_valid` low produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | DATA_W | Input byte |
| in_ready | output | 1 | Engine can take a byte |
| mem_valid | output | 1 | Memory write strobe |
| mem_addr | output | PFN_W+PAGE_W | Memory write byte address |
| mem_data | output | DATA_W | Memory write data |
| pt_we | input | 1 | Page table write enable |
| pt_buf | input | clog2(NBUF) | Buffer selected for table write |
| pt_page | input | clog2(MAX_PAGES) | Page slot selected for table write |
| pt_pfn | input | PFN_W | Page frame number to store |
| cfg_enable | input | 1 | Run enable |
| cfg_pages | input | clog2(MAX_PAGES)+1 | Pages per buffer, same for all buffers |
| cfg_stride | input | clog2(MAX_PAGES)+PAGE_W+1 | Bytes per completion |
| irq_clear | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Completion interrupt |
| irq_buf | output | clog2(NBUF) | Index of the most recently completed buffer |
| irq_stamp | output | TS_W | Timestamp of that completion |
| irq_overrun | output | 1 | Completion arrived while irq was pending |
| cfg_err | output | 1 | Configuration rejected |

## Verification
A handshaken byte reaches the memory port after the second rising edge. The interrupt, index and timestamp of a completion change on that same edge. `in_ready` and `cfg_err` follow a change of enable by two edges. The bench samples on the falling edge. A monitor pairs every write strobe with the next byte expected from its own offset and buffer counters, so a write can be neither early, late nor missing without breaking the address, data or completion-count checks. Level checks such as the ready, error and overrun flags are taken at least two falling edges after the stimulus that sets them.

// File: rtl/sgcap_pkg.sv
package sgcap_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_BAD  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/sgcap_pagetab.sv
module sgcap_pagetab #(
  parameter int DEPTH = 2048,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [PFN_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [PFN_W-1:0] rdata
);
  logic [PFN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sgcap_engine.sv
module sgcap_engine
  import sgcap_pkg::*;
#(
  parameter int NBUF      = 8,
  parameter int MAX_PAGES = 256,
  parameter int PAGE_W    = 12,
  localparam int BUF_W = $clog2(NBUF),
  localparam int PG_W  = $clog2(MAX_PAGES),
  localparam int CNT_W = PG_W + 1,
  localparam int LEN_W = PG_W + PAGE_W + 1,
  localparam int OFF_W = PG_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [CNT_W-1:0]  cfg_pages,
  input  logic [LEN_W-1:0]  cfg_stride,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              cfg_err,
  output logic              take,
  output logic              last,
  output logic [BUF_W-1:0]  cur_buf,
  output logic [BUF_W+PG_W-1:0] tab_idx,
  output logic [PAGE_W-1:0] off_lo
);
  eng_state_e       state;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] buf_len;
  logic             bad_cfg;

  assign buf_len = LEN_W'(cfg_pages) << PAGE_W;
  assign bad_cfg = (cfg_pages == '0) || (cfg_pages > CNT_W'(MAX_PAGES)) ||
                   (cfg_stride == '0) || (cfg_stride > buf_len);

  assign in_ready = (state == ENG_RUN);
  assign cfg_err  = (state == ENG_BAD);
  assign take     = in_valid && in_ready;
  assign last     = ({1'b0, off} + LEN_W'(1)) == cfg_stride;
  assign tab_idx  = {cur_buf, off[OFF_W-1:PAGE_W]};
  assign off_lo   = off[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      cur_buf <= '0;
      off     <= '0;
    end else if (!cfg_enable) begin
      state   <= ENG_IDLE;
      cur_buf <= '0;
      off     <= '0;
    end else begin
      case (state)
        ENG_IDLE: state <= bad_cfg ? ENG_BAD : ENG_RUN;
        ENG_RUN: begin
          if (take) begin
            if (last) begin
              off     <= '0;
              cur_buf <= (cur_buf == BUF_W'(NBUF - 1)) ? '0 : cur_buf + 1'b1;
            end else begin
              off <= off + 1'b1;
            end
          end
        end
        default: state <= ENG_BAD;
      endcase
    end
  end

  // R3: running offset always stays below the stride
  assert_off_below_stride_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_RUN) |-> ({1'b0, off} < cfg_stride));
  // R8: a rejected configuration never accepts bytes
  assert_err_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !in_ready);
  // R9: disabling drops ready after the next edge
  assert_disable_drops_ready_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !in_ready);
endmodule

// File: rtl/sgcap_irq.sv
module sgcap_irq #(
  parameter int BUF_W = 3,
  parameter int TS_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [BUF_W-1:0] done_buf,
  input  logic             clear,
  output logic             irq,
  output logic [BUF_W-1:0] irq_buf,
  output logic [TS_W-1:0]  irq_stamp,
  output logic             overrun
);
  logic [TS_W-1:0] ts;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts        <= '0;
      irq       <= 1'b0;
      irq_buf   <= '0;
      irq_stamp <= '0;
      overrun   <= 1'b0;
    end else begin
      ts <= ts + 1'b1;
      if (done) begin
        irq       <= 1'b1;
        irq_buf   <= done_buf;
        irq_stamp <= ts;
        if (irq && !clear) overrun <= 1'b1;
        else if (clear)    overrun <= 1'b0;
      end else if (clear) begin
        irq     <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  // R4: the interrupt only rises right after a completion
  assert_irq_from_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(done));
  // R6: a clear with no competing completion drops the interrupt
  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (clear && !done) |=> (!irq && !overrun));
  // R7: overrun only exists while an interrupt is pending
  assert_overrun_needs_irq_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |-> irq);
endmodule

// File: rtl/sgcap_ring.sv
module sgcap_ring #(
  parameter int NBUF      = 8,
  parameter int MAX_PAGES = 256,
  parameter int PAGE_W    = 12,
  parameter int PFN_W     = 20,
  parameter int DATA_W    = 8,
  parameter int TS_W      = 32,
  localparam int BUF_W = $clog2(NBUF),
  localparam int PG_W  = $clog2(MAX_PAGES),
  localparam int CNT_W = PG_W + 1,
  localparam int LEN_W = PG_W + PAGE_W + 1,
  localparam int AW    = PFN_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_data,
  input  logic              pt_we,
  input  logic [BUF_W-1:0]  pt_buf,
  input  logic [PG_W-1:0]   pt_page,
  input  logic [PFN_W-1:0]  pt_pfn,
  input  logic              cfg_enable,
  input  logic [CNT_W-1:0]  cfg_pages,
  input  logic [LEN_W-1:0]  cfg_stride,
  input  logic              irq_clear,
  output logic              irq,
  output logic [BUF_W-1:0]  irq_buf,
  output logic [TS_W-1:0]   irq_stamp,
  output logic              irq_overrun,
  output logic              cfg_err
);
  localparam int TAB_DEPTH = (1 << BUF_W) * MAX_PAGES;

  logic                  take, last;
  logic [BUF_W-1:0]      cur_buf;
  logic [BUF_W+PG_W-1:0] tab_idx;
  logic [PAGE_W-1:0]     off_lo;
  logic [PFN_W-1:0]      pfn;

  logic                  s1_valid, s1_done;
  logic [DATA_W-1:0]     s1_data;
  logic [PAGE_W-1:0]     s1_off_lo;
  logic [BUF_W-1:0]      s1_buf;

  sgcap_engine #(.NBUF(NBUF), .MAX_PAGES(MAX_PAGES), .PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_pages(cfg_pages),
    .cfg_stride(cfg_stride), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_err(cfg_err), .take(take), .last(last), .cur_buf(cur_buf),
    .tab_idx(tab_idx), .off_lo(off_lo)
  );

  sgcap_pagetab #(.DEPTH(TAB_DEPTH), .PFN_W(PFN_W)) u_tab (
    .clk(clk), .we(pt_we), .waddr({pt_buf, pt_page}), .wdata(pt_pfn),
    .raddr(tab_idx), .rdata(pfn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_done   <= 1'b0;
      mem_valid <= 1'b0;
    end else begin
      s1_valid  <= take;
      s1_done   <= take && last;
      mem_valid <= s1_valid;
    end
    s1_data   <= in_data;
    s1_off_lo <= off_lo;
    s1_buf    <= cur_buf;
    mem_addr  <= {pfn, s1_off_lo};
    mem_data  <= s1_data;
  end

  sgcap_irq #(.BUF_W(BUF_W), .TS_W(TS_W)) u_irq (
    .clk(clk), .rst(rst), .done(s1_done), .done_buf(s1_buf), .clear(irq_clear),
    .irq(irq), .irq_buf(irq_buf), .irq_stamp(irq_stamp), .overrun(irq_overrun)
  );

  // R2: every write strobe follows an input handshake two edges earlier
  assert_write_follows_handshake_R2: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> $past(in_valid && in_ready, 2));
  // R4: the interrupt rises only together with a memory write
  assert_irq_with_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> mem_valid);
endmodule

// File: tb/tb_sgcap_ring.sv
`timescale 1ns/1ps
module tb_sgcap_ring;
  localparam int NBUF = 8, MAXP = 4, PW = 4, PFNW = 8;
  localparam int BUFW = 3, PGW = 2, CNTW = 3, LENW = 7, AW = PFNW + PW;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic mem_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_data;
  logic pt_we = 0;
  logic [BUFW-1:0] pt_buf = 0;
  logic [PGW-1:0] pt_page = 0;
  logic [PFNW-1:0] pt_pfn = 0;
  logic cfg_enable = 0;
  logic [CNTW-1:0] cfg_pages = 0;
  logic [LENW-1:0] cfg_stride = 0;
  logic irq_clear, irq, irq_overrun, cfg_err;
  logic [BUFW-1:0] irq_buf;
  logic [31:0] irq_stamp;

  logic auto_clr = 1, auto_pulse = 0, man_clr = 0;
  assign irq_clear = auto_clr ? auto_pulse : man_clr;

  int nvec = 0, nerr = 0, cyc = 0;
  int exp_buf = 0, exp_off = 0, cur_stride = 1;
  int sent_cnt = 0, rcv_cnt = 0, wcount = 0, icount = 0;

  always #4 clk = ~clk;

  sgcap_ring #(.NBUF(NBUF), .MAX_PAGES(MAXP), .PAGE_W(PW), .PFN_W(PFNW),
               .DATA_W(8), .TS_W(32)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .pt_we(pt_we), .pt_buf(pt_buf), .pt_page(pt_page), .pt_pfn(pt_pfn),
    .cfg_enable(cfg_enable), .cfg_pages(cfg_pages), .cfg_stride(cfg_stride),
    .irq_clear(irq_clear), .irq(irq), .irq_buf(irq_buf), .irq_stamp(irq_stamp),
    .irq_overrun(irq_overrun), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] pfn_of(int b, int p);
    return 8'((b * MAXP + p) * 3 + 5);
  endfunction
  function automatic logic [7:0] byte_of(int n);
    return 8'(n * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d, expected %0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // Monitor: follows writes with its own offset/buffer model
  always @(negedge clk) begin : mon
    bit comp;
    int ea;
    comp = 0;
    if (!rst && mem_valid) begin
      ea = int'(pfn_of(exp_buf, exp_off >> PW)) * (1 << PW) + (exp_off % (1 << PW));
      chk(mem_addr == AW'(ea), "R1 write address", mem_addr, ea);
      chk(mem_data == byte_of(rcv_cnt), "R2 write data", mem_data, byte_of(rcv_cnt));
      rcv_cnt++;
      wcount++;
      if (exp_off + 1 == cur_stride) begin
        comp = 1;
        icount++;
        chk(irq == 1'b1, "R4 irq with last byte", irq, 1);
        chk(irq_buf == BUFW'(exp_buf), "R3 completed buffer index", irq_buf, exp_buf);
        chk(irq_stamp == 32'(cyc - 1), "R5 timestamp", irq_stamp, cyc - 1);
        if (auto_clr) chk(irq_overrun == 1'b0, "R6 clear before next completion", irq_overrun, 0);
        exp_off = 0;
        exp_buf = (exp_buf + 1) % NBUF;
      end else begin
        exp_off++;
        if (auto_clr) chk(irq == 1'b0, "R6 irq cleared", irq, 0);
      end
    end
    auto_pulse = comp;
  end

  task automatic set_cfg(int pages, int stride);
    @(negedge clk);
    cfg_enable = 0;
    in_valid = 0;
    repeat (3) @(negedge clk);
    cfg_pages = CNTW'(pages);
    cfg_stride = LENW'(stride);
    exp_buf = 0;
    exp_off = 0;
    cur_stride = stride;
    cfg_enable = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic push(int n, bit gaps);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (gaps && (k % 3 == 1)) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data = byte_of(sent_cnt);
      sent_cnt++;
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic stream(int pages, int stride, int n, bit gaps);
    int w0, i0;
    set_cfg(pages, stride);
    chk(in_ready == 1'b1, "R10 ready after valid enable", in_ready, 1);
    chk(cfg_err == 1'b0, "R10 no config error", cfg_err, 0);
    w0 = wcount;
    i0 = icount;
    push(n, gaps);
    repeat (4) @(negedge clk);
    chk(wcount == w0 + n, "R2 one write per byte", wcount - w0, n);
    chk(icount == i0 + n / stride, "R4 one irq per stride", icount - i0, n / stride);
  endtask

  task automatic bad_cfg(int pages, int stride);
    set_cfg(pages, stride);
    chk(cfg_err == 1'b1, "R8 config rejected", cfg_err, 1);
    chk(in_ready == 1'b0, "R8 ready held low", in_ready, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    int w0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(in_ready == 0, "R10 reset ready", in_ready, 0);
    chk(mem_valid == 0, "R2 reset write strobe", mem_valid, 0);
    chk(irq == 0, "R4 reset irq", irq, 0);
    chk(irq_overrun == 0, "R7 reset overrun", irq_overrun, 0);
    chk(cfg_err == 0, "R8 reset error", cfg_err, 0);

    for (int b = 0; b < NBUF; b++)
      for (int p = 0; p < MAXP; p++) begin
        @(negedge clk);
        pt_we = 1;
        pt_buf = BUFW'(b);
        pt_page = PGW'(p);
        pt_pfn = pfn_of(b, p);
      end
    @(negedge clk);
    pt_we = 0;

    // R1 R3 sweeps over page counts and strides, incl. stride 1 and full length
    stream(1, 16, 40, 0);
    stream(2, 5, 47, 1);
    stream(4, 64, 140, 0);
    stream(3, 1, 20, 1);
    stream(2, 20, 70, 1);
    stream(4, 37, 160, 1);

    // R9: stop mid-buffer, hold valid while disabled, restart at buffer 0
    stream(2, 5, 7, 0);
    @(negedge clk);
    cfg_enable = 0;
    w0 = wcount;
    @(negedge clk);
    in_valid = 1;
    in_data = 8'hEE;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(in_ready == 0, "R9 ready low while disabled", in_ready, 0);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    chk(wcount == w0, "R10 no write while not ready", wcount - w0, 0);
    stream(2, 5, 6, 0);

    // R6 / R7: pending interrupt, overrun, clear
    auto_clr = 0;
    set_cfg(1, 4);
    push(4, 0);
    repeat (3) @(negedge clk);
    chk(irq == 1, "R6 irq pending", irq, 1);
    chk(irq_overrun == 0, "R7 no overrun yet", irq_overrun, 0);
    repeat (6) @(negedge clk);
    chk(irq == 1, "R6 irq held until clear", irq, 1);
    push(4, 0);
    repeat (3) @(negedge clk);
    chk(irq_overrun == 1, "R7 overrun set", irq_overrun, 1);
    chk(irq_buf == 1, "R7 newest index reported", irq_buf, 1);
    man_clr = 1;
    @(negedge clk);
    man_clr = 0;
    chk(irq == 0, "R6 clear drops irq", irq, 0);
    chk(irq_overrun == 0, "R6 clear drops overrun", irq_overrun, 0);
    auto_clr = 1;

    // R8: rejected configurations, then one at the exact limit
    bad_cfg(4, 0);
    bad_cfg(4, 65);
    bad_cfg(1, 17);
    bad_cfg(0, 1);
    bad_cfg(5, 4);
    @(negedge clk);
    cfg_enable = 0;
    repeat (2) @(negedge clk);
    chk(cfg_err == 0, "R8 error cleared by disable", cfg_err, 0);
    stream(1, 16, 16, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule